// File: doc/BRIEF.md
# Partial-Word Load and Store Merger

This block carries out the four partial-word memory operations of a 32-bit load/store core: the two loads that merge part of a memory word into a register, and the two stores that merge part of a register into a memory word. A caller gives it an operation kind, a byte address and the current value of the register involved, and pulses a start strobe. The block issues every memory access to the word that holds the addressed byte. It then either returns the merged register value or writes the merged word back to memory. It signals completion with a one-cycle done pulse.

A load takes a single memory read. A store takes a read of the aligned word followed by a write of the merged word to the same address. The register value can come from a side input that carries a load result not yet committed to the register file, so a partial load placed straight after an ordinary load merges into the newest value. The memory port uses a request/ready handshake, and read data returns on a separate valid strobe.

Top module: `split_word_unit`

## Requirements
- R1: Every memory request carries the byte address with its two low bits forced to zero.
- R2: Kind 2'b00 (left load) at byte offset k = addr[1:0]: the result takes memory bytes 0..k into register bytes 3-k..3 and keeps register bytes below 3-k. For k = 0..3 the kept register mask is 0x00FFFFFF, 0x0000FFFF, 0x000000FF, 0, and the memory word is shifted left by 24, 16, 8, 0.
- R3: Kind 2'b01 (right load) at offset k: the result takes memory bytes k..3 into register bytes 0..3-k and keeps the register bytes above. The kept masks are 0, 0xFF000000, 0xFFFF0000, 0xFFFFFF00, and the memory shifts right by 0, 8, 16, 24.
- R4: Kind 2'b10 (left store) at offset k: the word written keeps the memory bytes above k and places register bytes 3-k..3 in bytes 0..k. The kept masks are 0xFFFFFF00, 0xFFFF0000, 0xFF000000, 0, and the register shifts right by 24, 16, 8, 0.
- R5: Kind 2'b11 (right store) at offset k: the word written keeps the memory bytes below k and places register bytes 0..3-k in bytes k..3. The kept masks are 0, 0x000000FF, 0x0000FFFF, 0x00FFFFFF, and the register shifts left by 0, 8, 16, 24.
- R6: When fwd_valid_i is high with start_i, fwd_data_i replaces reg_i as the register value that is merged or stored.
- R7: A store makes exactly one read and then one write to the same aligned address. Request, address, direction and write data hold while ready is low. done_o pulses in the cycle after the write is accepted.
- R8: A load makes exactly one read and no write. result_o carries the merged value and done_o pulses in the cycle after read data returns.
- R9: A start_i pulse that arrives while an operation is in progress is ignored: it causes no extra memory access and does not alter the result.
- R10: After reset done_o is low, no memory request is pending and result_o is zero. done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| kind_i | input | 2 | 00 left load, 01 right load, 10 left store, 11 right store |
| addr_i | input | ADDR_W | Byte address |
| reg_i | input | DATA_W | Current register value |
| fwd_valid_i | input | 1 | A pending load value overrides reg_i |
| fwd_data_i | input | DATA_W | Pending load value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Aligned word address |
| mem_wdata_o | output | DATA_W | Merged word for a store |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| result_o | output | DATA_W | Merged register value from the last load |
| done_o | output | 1 | Operation finished (one cycle) |

## Verification
The properties assume that memory raises mem_rvalid_i exactly once for each accepted read, always after the accept, and never otherwise. They also assume that mem_ready_i may stall a request for any number of cycles. The bench memory model follows this contract. It answers each accepted read with one valid pulse on the next edge, and its ready line is driven by a free-running shift register, so stalls land on both the read and the write phases. The bench raises start_i only when the block is idle, except for the deliberate mid-operation pulse that tests the ignore rule.

// File: rtl/split_word_pkg.sv
package split_word_pkg;

   typedef enum logic [1:0] {
      PW_LD_LEFT  = 2'b00,
      PW_LD_RIGHT = 2'b01,
      PW_ST_LEFT  = 2'b10,
      PW_ST_RIGHT = 2'b11
   } pw_kind_e;

   typedef enum logic [1:0] {
      PW_IDLE,
      PW_READ,
      PW_WAIT,
      PW_WRITE
   } pw_state_e;

   function automatic logic pw_is_store(pw_kind_e k);
      return (k == PW_ST_LEFT) || (k == PW_ST_RIGHT);
   endfunction

endpackage

// File: rtl/split_word_lanes.sv
module split_word_lanes
   import split_word_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  pw_kind_e                         kind_i,
   input  logic [$clog2(DATA_W/8)-1:0]      off_i,
   input  logic [DATA_W-1:0]                reg_i,
   input  logic [DATA_W-1:0]                mem_i,
   output logic [DATA_W-1:0]                merged_o
);

   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   if ((DATA_W % 8) != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_width
      $error("split_word_lanes: DATA_W must be a power-of-two count of bytes");
   end

   // rev is the lane count above the offset: the shift for the "left" kinds
   logic [OFF_W-1:0]  rev;
   logic [DATA_W-1:0] ll_w, lr_w, sl_w, sr_w;

   assign rev  = OFF_W'(LANES - 1) - off_i;
   assign ll_w = mem_i << {rev,   3'b000};
   assign lr_w = mem_i >> {off_i, 3'b000};
   assign sl_w = reg_i >> {rev,   3'b000};
   assign sr_w = reg_i << {off_i, 3'b000};

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam logic [OFF_W-1:0] JL = OFF_W'(j);
      logic [7:0] lane_v;

      always_comb begin
         unique case (kind_i)
            PW_LD_LEFT:  lane_v = (JL >= rev)   ? ll_w[j*8 +: 8] : reg_i[j*8 +: 8];
            PW_LD_RIGHT: lane_v = (JL <= rev)   ? lr_w[j*8 +: 8] : reg_i[j*8 +: 8];
            PW_ST_LEFT:  lane_v = (JL <= off_i) ? sl_w[j*8 +: 8] : mem_i[j*8 +: 8];
            PW_ST_RIGHT: lane_v = (JL >= off_i) ? sr_w[j*8 +: 8] : mem_i[j*8 +: 8];
            default:     lane_v = reg_i[j*8 +: 8];
         endcase
      end

      assign merged_o[j*8 +: 8] = lane_v;
   end

endmodule

// File: rtl/split_word_ctrl.sv
module split_word_ctrl
   import split_word_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  pw_kind_e                      kind_i,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic [DATA_W-1:0]             regv_i,
   input  logic                          mem_ready_i,
   input  logic                          mem_rvalid_i,
   input  logic [DATA_W-1:0]             merged_i,
   output pw_kind_e                      kind_o,
   output logic [$clog2(DATA_W/8)-1:0]   off_o,
   output logic [DATA_W-1:0]             regv_o,
   output logic                          mem_req_o,
   output logic                          mem_we_o,
   output logic [ADDR_W-1:0]             mem_addr_o,
   output logic [DATA_W-1:0]             mem_wdata_o,
   output logic [DATA_W-1:0]             result_o,
   output logic                          done_o
);

   localparam int OFF_W = $clog2(DATA_W / 8);

   pw_state_e         state_q;
   pw_kind_e          kind_q;
   logic [OFF_W-1:0]  off_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] regv_q, wdata_q, result_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PW_IDLE;
         kind_q   <= PW_LD_LEFT;
         off_q    <= '0;
         addr_q   <= '0;
         regv_q   <= '0;
         wdata_q  <= '0;
         result_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            PW_IDLE: if (start_i) begin
               kind_q  <= kind_i;
               off_q   <= addr_i[OFF_W-1:0];
               addr_q  <= {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
               regv_q  <= regv_i;
               state_q <= PW_READ;
            end
            PW_READ: if (mem_ready_i) state_q <= PW_WAIT;
            PW_WAIT: if (mem_rvalid_i) begin
               if (pw_is_store(kind_q)) begin
                  wdata_q <= merged_i;
                  state_q <= PW_WRITE;
               end else begin
                  result_q <= merged_i;
                  done_q   <= 1'b1;
                  state_q  <= PW_IDLE;
               end
            end
            PW_WRITE: if (mem_ready_i) begin
               done_q  <= 1'b1;
               state_q <= PW_IDLE;
            end
            default: state_q <= PW_IDLE;
         endcase
      end
   end

   assign kind_o      = kind_q;
   assign off_o       = off_q;
   assign regv_o      = regv_q;
   assign mem_req_o   = (state_q == PW_READ) || (state_q == PW_WRITE);
   assign mem_we_o    = (state_q == PW_WRITE);
   assign mem_addr_o  = addr_q;
   assign mem_wdata_o = wdata_q;
   assign result_o    = result_q;
   assign done_o      = done_q;

endmodule

// File: rtl/split_word_unit.sv
module split_word_unit
   import split_word_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter bit FWD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        kind_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] reg_i,
   input  logic              fwd_valid_i,
   input  logic [DATA_W-1:0] fwd_data_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_ready_i,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [DATA_W-1:0] result_o,
   output logic              done_o
);

   localparam int OFF_W = $clog2(DATA_W / 8);

   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("split_word_unit: ADDR_W too narrow for the byte offset");
   end

   logic [DATA_W-1:0] regv_sel;
   pw_kind_e          kind_q;
   logic [OFF_W-1:0]  off_q;
   logic [DATA_W-1:0] regv_q, merged;

   if (FWD_EN) begin : g_fwd
      assign regv_sel = fwd_valid_i ? fwd_data_i : reg_i;
   end else begin : g_nofwd
      logic unused_fwd;
      assign unused_fwd = fwd_valid_i ^ (^fwd_data_i);
      assign regv_sel   = reg_i;
   end

   split_word_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .kind_i       (pw_kind_e'(kind_i)),
      .addr_i       (addr_i),
      .regv_i       (regv_sel),
      .mem_ready_i  (mem_ready_i),
      .mem_rvalid_i (mem_rvalid_i),
      .merged_i     (merged),
      .kind_o       (kind_q),
      .off_o        (off_q),
      .regv_o       (regv_q),
      .mem_req_o    (mem_req_o),
      .mem_we_o     (mem_we_o),
      .mem_addr_o   (mem_addr_o),
      .mem_wdata_o  (mem_wdata_o),
      .result_o     (result_o),
      .done_o       (done_o)
   );

   split_word_lanes #(.DATA_W(DATA_W)) u_lanes (
      .kind_i   (kind_q),
      .off_i    (off_q),
      .reg_i    (regv_q),
      .mem_i    (mem_rdata_i),
      .merged_o (merged)
   );

endmodule

// File: rtl/split_word_chk.sv
module split_word_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [1:0]        kind_i,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic              mem_ready_i,
   input logic              mem_rvalid_i,
   input logic              done_o
);

   localparam int OFF_W = $clog2(DATA_W / 8);

   logic busy_m, store_m, read_seen_m;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_m      <= 1'b0;
         store_m     <= 1'b0;
         read_seen_m <= 1'b0;
      end else begin
         if (start_i && (!busy_m || done_o)) begin
            busy_m      <= 1'b1;
            store_m     <= kind_i[1];
            read_seen_m <= 1'b0;
         end else begin
            if (done_o) busy_m <= 1'b0;
            if (mem_req_o && mem_ready_i && !mem_we_o) read_seen_m <= 1'b1;
         end
      end
   end

   a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (mem_addr_o[OFF_W-1:0] == '0));

   a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

   a_r7_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> (busy_m && store_m && read_seen_m));

   a_r8_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_m && !store_m) |-> !(mem_req_o && mem_we_o));

   a_r8_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !store_m) |-> $past(mem_rvalid_i));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_m |-> !mem_req_o);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

bind split_word_unit split_word_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .kind_i       (kind_i),
   .mem_req_o    (mem_req_o),
   .mem_we_o     (mem_we_o),
   .mem_addr_o   (mem_addr_o),
   .mem_wdata_o  (mem_wdata_o),
   .mem_ready_i  (mem_ready_i),
   .mem_rvalid_i (mem_rvalid_i),
   .done_o       (done_o)
);

// File: tb/split_word_unit_tb.sv
module split_word_unit_tb;

   typedef struct {
      bit          is_store;
      logic [31:0] exp;
      int          idx;
      logic [31:0] aaddr;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  kind_i = '0;
   logic [31:0] addr_i = '0, reg_i = '0, fwd_data_i = '0;
   logic        fwd_valid_i = 1'b0;
   logic        mem_req_o, mem_we_o, done_o;
   logic [31:0] mem_addr_o, mem_wdata_o, result_o;
   logic        mem_ready_i;
   logic        mem_rvalid_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;

   logic [31:0] mem [0:15];
   logic [7:0]  lfsr = 8'h5A;
   bit          stall_en = 1'b0;
   item_t       exp_q[$];
   int          checks = 0, errors = 0, done_cnt = 0;
   int          rd_cnt = 0, wr_cnt = 0;
   bit          rv_prev = 1'b0, wacc_prev = 1'b0, bad_addr = 1'b0;

   always #5 clk = ~clk;

   split_word_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i), .addr_i(addr_i),
      .reg_i(reg_i), .fwd_valid_i(fwd_valid_i), .fwd_data_i(fwd_data_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rvalid_i(mem_rvalid_i),
      .mem_rdata_i(mem_rdata_i), .result_o(result_o), .done_o(done_o));

   assign mem_ready_i = !stall_en || lfsr[0] || lfsr[1];

   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rvalid_i <= 1'b0;
      if (mem_req_o && mem_ready_i) begin
         if (mem_we_o) mem[mem_addr_o[5:2]] <= mem_wdata_o;
         else begin
            mem_rvalid_i <= 1'b1;
            mem_rdata_i  <= mem[mem_addr_o[5:2]];
         end
      end
   end

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_merge(logic [1:0] k, logic [1:0] o,
                                             logic [31:0] r, logic [31:0] m);
      case (k)
         2'b00: case (o)
            2'd0: return (r & 32'h00FFFFFF) | (m << 24);
            2'd1: return (r & 32'h0000FFFF) | (m << 16);
            2'd2: return (r & 32'h000000FF) | (m << 8);
            default: return m;
         endcase
         2'b01: case (o)
            2'd0: return m;
            2'd1: return (r & 32'hFF000000) | (m >> 8);
            2'd2: return (r & 32'hFFFF0000) | (m >> 16);
            default: return (r & 32'hFFFFFF00) | (m >> 24);
         endcase
         2'b10: case (o)
            2'd0: return (m & 32'hFFFFFF00) | (r >> 24);
            2'd1: return (m & 32'hFFFF0000) | (r >> 16);
            2'd2: return (m & 32'hFF000000) | (r >> 8);
            default: return r;
         endcase
         default: case (o)
            2'd0: return r;
            2'd1: return (m & 32'h000000FF) | (r << 8);
            2'd2: return (m & 32'h0000FFFF) | (r << 16);
            default: return (m & 32'h00FFFFFF) | (r << 24);
         endcase
      endcase
   endfunction

   // monitor: pops the scoreboard on each done pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (done_o) begin
            done_cnt++;
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
            else begin
               item_t it;
               it = exp_q.pop_front();
               if (it.is_store) begin
                  chk(mem[it.idx] === it.exp, it.tag, mem[it.idx], it.exp);
                  chk(rd_cnt == 1 && wr_cnt == 1 && wacc_prev, "R7 store sequence/timing",
                      32'(rd_cnt * 16 + wr_cnt), 32'h11);
               end else begin
                  chk(result_o === it.exp, it.tag, result_o, it.exp);
                  chk(rd_cnt == 1 && wr_cnt == 0 && rv_prev, "R8 load sequence/timing",
                      32'(rd_cnt * 16 + wr_cnt), 32'h10);
               end
               chk(!bad_addr, "R1 aligned address", 32'(bad_addr), 32'd0);
            end
            rd_cnt = 0; wr_cnt = 0; bad_addr = 1'b0;
         end
         if (mem_req_o && mem_ready_i) begin
            if (mem_we_o) wr_cnt++; else rd_cnt++;
            if (exp_q.size() == 0 || mem_addr_o !== exp_q[0].aaddr) bad_addr = 1'b1;
         end
         rv_prev   = mem_rvalid_i;
         wacc_prev = mem_req_o && mem_ready_i && mem_we_o;
      end
   end

   task automatic run_op(logic [1:0] k, logic [31:0] a, logic [31:0] r,
                         bit fv, logic [31:0] fd, bit intrude, string tag);
      item_t it;
      int    target;
      logic [31:0] eff;
      eff         = fv ? fd : r;
      it.is_store = k[1];
      it.idx      = int'(a[5:2]);
      it.aaddr    = {a[31:2], 2'b00};
      it.exp      = ref_merge(k, a[1:0], eff, mem[a[5:2]]);
      it.tag      = tag;
      exp_q.push_back(it);
      target = done_cnt + 1;
      @(negedge clk);
      start_i = 1'b1; kind_i = k; addr_i = a; reg_i = r; fwd_valid_i = fv; fwd_data_i = fd;
      @(negedge clk);
      if (intrude) begin
         kind_i = ~k; addr_i = a + 32'd5; reg_i = ~r; fwd_valid_i = 1'b0;
      end else start_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0; fwd_valid_i = 1'b0;
      while (done_cnt < target) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      string tags[4];
      tags[0] = "R2 left load"; tags[1] = "R3 right load";
      tags[2] = "R4 left store"; tags[3] = "R5 right store";
      for (int j = 0; j < 16; j++) mem[j] = 32'hA1B2C3D4 ^ (32'(j) * 32'h01030507);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_o == 1'b0 && mem_req_o == 1'b0 && result_o == 32'd0, "R10 reset state",
          {result_o[29:0], mem_req_o, done_o}, 32'd0);

      // every kind at every offset, memory always ready
      for (int k = 0; k < 4; k++)
         for (int o = 0; o < 4; o++)
            run_op(2'(k), 32'h4000_0000 + 32'(k * 16) + 32'(o),
                   32'h1122_3344 + 32'(o * 32'h0101_0101), 1'b0, 32'd0, 1'b0, tags[k]);

      // with memory stalls, other data patterns and offsets
      stall_en = 1'b1;
      for (int n = 0; n < 24; n++)
         run_op(2'(n % 4), 32'h8000_0000 + 32'((n * 7) % 64),
                32'hF00D_0000 ^ 32'(n * 32'h0013_1F07), 1'b0, 32'd0, 1'b0, tags[n % 4]);

      // pending load value overrides the register input
      for (int k = 0; k < 4; k++)
         run_op(2'(k), 32'h0000_0020 + 32'(k), 32'hDEAD_BEEF, 1'b1,
                32'h5566_7788 + 32'(k), 1'b0, "R6 forwarded value");

      // start pulse during a busy operation is ignored
      for (int k = 0; k < 4; k++)
         run_op(2'(k), 32'h0000_0031 + 32'(k), 32'hCAFE_F00D, 1'b0, 32'd0, 1'b1,
                "R9 ignored start");

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0 && done_o == 1'b0, "R9 no extra completion",
          32'(exp_q.size()), 32'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule